// File: doc/BRIEF.md
# Accumulator ALU with Packed Flag Register

This block is the arithmetic and logic unit of an 8-bit accumulator processor. In a single cycle it combines the accumulator operand with a second operand under one of eight operations: add, add with carry, subtract, subtract with borrow, bitwise AND, XOR, OR, and compare. The result comes out combinationally and is paired with a write-back strobe. The four status flags are captured in an 8-bit register on the clock edge that ends the operation.

The flag register has a fixed packed layout:

| Bit | Flag |
|-----|------|
| 7 | Zero |
| 6 | Subtract |
| 5 | Half-carry |
| 4 | Carry |
| 3..0 | Always zero |

Software state can also be loaded straight into the register through a direct write port, for example when flags are restored from the stack. The low nibble is still forced to zero on that path.

The operation is chosen by a 3-bit code:

| Code | Operation |
|------|-----------|
| 0 | ADD |
| 1 | ADC |
| 2 | SUB |
| 3 | SBC |
| 4 | AND |
| 5 | XOR |
| 6 | OR |
| 7 | CP (compare) |

Compare computes A−B for the flags only. It leaves the accumulator untouched because it raises no write-back strobe.

Top module: `acc_alu`

## Requirements
- R1: For ADD (code 0) and ADC (code 1), `alu_result` = (A + B + cin) mod 256. cin is 0 for ADD and is the stored carry flag (bit 4) for ADC. The new carry flag is the carry out of bit 7.
- R2: For SUB (code 2), SBC (code 3) and CP (code 7), the difference is (A − B − cin) mod 256. cin is the stored carry flag for SBC only. The new carry flag is set when a borrow into bit 7 occurs, that is when A < B + cin.
- R3: For the add and subtract operations, the new half-carry flag (bit 5) reports a carry out of bit 3 (add) or a borrow into bit 3 (subtract). The nibble computation includes cin for ADC and SBC.
- R4: The new subtract flag (bit 6) is 1 after SUB, SBC and CP, and 0 after ADD, ADC, AND, XOR and OR.
- R5: The new zero flag (bit 7) is 1 exactly when the 8-bit result of the operation is zero. For CP, the result used is the difference.
- R6: AND, XOR and OR (codes 4, 5, 6) output the bitwise result. AND sets the half-carry flag to 1 and the carry flag to 0. XOR and OR clear both flags. The incoming carry flag has no effect on these operations.
- R7: `res_we` is high when `op_valid` is high and the code is not CP. It is low for CP and whenever `op_valid` is low.
- R8: The flag register keeps Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 read as 0 at all times, including after a direct write of ones.
- R9: The flag register changes only on a rising clock edge where `op_valid` or `flag_wr` is high, and otherwise holds. A synchronous active-low reset clears it to 0x00.
- R10: When `flag_wr` and `op_valid` are both high at an edge, the direct write wins and the register takes `flag_wdata` with its low nibble cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute strobe: performs the operation and enables the flag update |
| op_code | input | 3 | Operation select, encoding as listed above |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| flag_wr | input | 1 | Direct load of the flag register |
| flag_wdata | input | 8 | Value for the direct load; low nibble discarded |
| alu_result | output | 8 | Combinational operation result |
| res_we | output | 1 | Result write-back strobe |
| flags | output | 8 | Registered flags {Z,N,H,C,0000} |

## Verification
`alu_result` and `res_we` are combinational and due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples them one nanosecond later, before the next rising edge. The flags are one register stage behind: they are due after the rising edge that ends the operation cycle, so the bench reads them at the following falling edge. The incoming carry for each vector is first set through the direct write port one cycle earlier, and that preset value is itself checked. This separates the ADC/SBC carry path from any leftover state.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes and flag bit positions for the accumulator ALU.
// Assumes an 8-bit flag byte with the status nibble in the upper half.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    localparam int FLAG_W = 8;
    localparam int FLG_Z  = 7;
    localparam int FLG_N  = 6;
    localparam int FLG_H  = 5;
    localparam int FLG_C  = 4;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } status_t;

endpackage

// File: rtl/acc_alu_addsub.sv
// Module: adder/subtractor with carry-in that reports both the full carry and the
// carry or borrow at the half-width boundary. Assumes DATA_W is even.
module acc_alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              subtract,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              half
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] wide;
    logic [HALF_W:0] nib;

    // Full-width and lower-half arithmetic, carry-in folded into both.
    always_comb begin
        if (subtract) begin
            wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            nib  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        end
    end

    // Result bits and the two carry/borrow indications.
    always_comb begin
        sum   = wide[DATA_W-1:0];
        carry = wide[DATA_W];
        half  = nib[HALF_W];
    end

endmodule

// File: rtl/acc_alu_bitwise.sv
// Module: bitwise AND / XOR / OR unit. sel: 0 = AND, 1 = XOR, 2 or 3 = OR.
// Assumes the caller decodes which operation is logical.
module acc_alu_bitwise #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        unique case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a ^ b;
            default: y = a | b;
        endcase
    end

endmodule

// File: rtl/acc_alu_flagreg.sv
// Module: packed flag register {Z,N,H,C,0000}. A direct write takes priority over an
// operation update. Synchronous active-low reset to zero.
module acc_alu_flagreg
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  status_t           upd_flags,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags_q
);
    // Capture flags: reset, then direct write, then operation update, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en) begin
            flags_q <= {wr_data[FLAG_W-1:4], 4'b0000};
        end else if (upd_en) begin
            flags_q <= {upd_flags, 4'b0000};
        end
    end

    assert_low_nibble_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags_q[3:0] == 4'b0000);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd_en) |=> $stable(flags_q));

    assert_direct_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_en) |=> flags_q[7:4] == $past(wr_data[7:4]));

endmodule

// File: rtl/acc_alu.sv
// Module: top of the 8-bit accumulator ALU. Decodes the operation code, runs the
// arithmetic and bitwise datapaths, forms the new status and the write-back strobe.
// Assumes result consumers sample alu_result in the same cycle as op_valid.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [DATA_W-1:0] alu_result,
    output logic              res_we,
    output logic [FLAG_W-1:0] flags
);
    alu_op_e           op;
    logic              is_sub;
    logic              is_logic;
    logic              use_cin;
    logic              cin;
    logic [DATA_W-1:0] arith_y;
    logic              arith_c;
    logic              arith_h;
    logic [DATA_W-1:0] logic_y;
    logic [1:0]        logic_sel;
    status_t           nxt;

    // Decode the operation class and the carry-in source.
    always_comb begin
        op        = alu_op_e'(op_code);
        is_sub    = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        is_logic  = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
        use_cin   = (op == OP_ADC) || (op == OP_SBC);
        cin       = use_cin & flags[FLG_C];
        logic_sel = (op == OP_AND) ? 2'd0 : (op == OP_XOR) ? 2'd1 : 2'd2;
    end

    acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .subtract (is_sub),
        .cin      (cin),
        .sum      (arith_y),
        .carry    (arith_c),
        .half     (arith_h)
    );

    acc_alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (logic_sel),
        .y   (logic_y)
    );

    // Pick the result and build the new status nibble.
    always_comb begin
        alu_result = is_logic ? logic_y : arith_y;
        nxt.z      = (alu_result == '0);
        nxt.n      = is_sub;
        nxt.h      = is_logic ? (op == OP_AND) : arith_h;
        nxt.c      = is_logic ? 1'b0 : arith_c;
        res_we     = op_valid && (op != OP_CMP);
    end

    acc_alu_flagreg u_flagreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (op_valid),
        .upd_flags (nxt),
        .wr_en     (flag_wr),
        .wr_data   (flag_wdata),
        .flags_q   (flags)
    );

    assert_cmp_no_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd7) |-> !res_we);

    assert_idle_no_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !res_we);

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_wr && op_code != 3'd7) |=>
            flags[FLG_Z] == ($past(alu_result) == '0));

    assert_sub_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_wr) |=>
            flags[FLG_N] == ($past(op_code) == 3'd2 || $past(op_code) == 3'd3 ||
                             $past(op_code) == 3'd7));

    assert_and_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_wr && op_code == 3'd4) |=> flags[5:4] == 2'b10);

endmodule

// File: tb/acc_alu_bench.sv
// Bench: vector table walked by one loop, then directed reset, hold and priority tests.
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [2:0] op_code;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic       flag_wr;
    logic [7:0] flag_wdata;
    logic [7:0] alu_result;
    logic       res_we;
    logic [7:0] flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .alu_result (alu_result),
        .res_we     (res_we),
        .flags      (flags)
    );

    // {op, a, b, carry_in, expected result, expected flags}
    localparam int NV = 19;
    localparam logic [35:0] VECS [0:NV-1] = '{
        {3'd0, 8'h3A, 8'hC6, 1'b0, 8'h00, 8'hB0},
        {3'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 8'h20},
        {3'd0, 8'h80, 8'h80, 1'b1, 8'h00, 8'h90},
        {3'd1, 8'hE1, 8'h0F, 1'b1, 8'hF1, 8'h20},
        {3'd1, 8'hFF, 8'h00, 1'b1, 8'h00, 8'hB0},
        {3'd2, 8'h3E, 8'h3E, 1'b0, 8'h00, 8'hC0},
        {3'd2, 8'h3E, 8'h0F, 1'b0, 8'h2F, 8'h60},
        {3'd2, 8'h3E, 8'h40, 1'b0, 8'hFE, 8'h50},
        {3'd2, 8'h10, 8'h01, 1'b1, 8'h0F, 8'h60},
        {3'd3, 8'h3B, 8'h2A, 1'b1, 8'h10, 8'h40},
        {3'd3, 8'h3B, 8'h4F, 1'b1, 8'hEB, 8'h70},
        {3'd3, 8'h00, 8'h00, 1'b1, 8'hFF, 8'h70},
        {3'd4, 8'h5A, 8'h3F, 1'b1, 8'h1A, 8'h20},
        {3'd4, 8'h5A, 8'hA5, 1'b0, 8'h00, 8'hA0},
        {3'd6, 8'h00, 8'h00, 1'b1, 8'h00, 8'h80},
        {3'd5, 8'hFF, 8'h0F, 1'b1, 8'hF0, 8'h00},
        {3'd7, 8'h3C, 8'h2F, 1'b0, 8'h00, 8'h60},
        {3'd7, 8'h3C, 8'h3C, 1'b1, 8'h00, 8'hC0},
        {3'd7, 8'h3C, 8'h40, 1'b0, 8'h00, 8'h50}
    };

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Result requirement tag by operation code.
    function automatic string res_req(input logic [2:0] op);
        if (op <= 3'd1)      return "R1";
        else if (op <= 3'd3) return "R2";
        else                 return "R6";
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0;
        flag_wr = 1'b0; flag_wdata = '0;
        repeat (3) @(negedge clk);
        check8("R9", "flags in reset", flags, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R9", "flags after reset", flags, 8'h00);

        // Vector table: preset carry through the direct write, then execute.
        for (int i = 0; i < NV; i++) begin
            logic [2:0] v_op;
            logic [7:0] v_a, v_b, v_res, v_flg;
            logic       v_cin;
            {v_op, v_a, v_b, v_cin, v_res, v_flg} = VECS[i];
            flag_wr    = 1'b1;
            flag_wdata = v_cin ? 8'h1F : 8'h0F;
            @(negedge clk);
            flag_wr = 1'b0;
            check8("R8", "preset flags, low nibble masked", flags, v_cin ? 8'h10 : 8'h00);
            op_valid = 1'b1; op_code = v_op; opnd_a = v_a; opnd_b = v_b;
            #1;
            if (v_op != 3'd7)
                check8(res_req(v_op), "result", alu_result, v_res);
            check8("R7", "write strobe", {7'd0, res_we}, {7'd0, v_op != 3'd7});
            @(negedge clk);
            op_valid = 1'b0;
            check8("R3/R4/R5", "flags", flags, v_flg);
            #1;
            check8("R7", "strobe idle", {7'd0, res_we}, 8'd0);
        end

        // R9: with no strobe, changing inputs leaves the flags alone.
        flag_wr = 1'b1; flag_wdata = 8'hA0;
        @(negedge clk);
        flag_wr = 1'b0; op_code = 3'd2; opnd_a = 8'h00; opnd_b = 8'h01;
        repeat (3) @(negedge clk);
        check8("R9", "flags hold without strobe", flags, 8'hA0);

        // R10: direct write wins over a simultaneous operation.
        op_valid = 1'b1; op_code = 3'd0; opnd_a = 8'h01; opnd_b = 8'h01;
        flag_wr = 1'b1; flag_wdata = 8'h5F;
        @(negedge clk);
        op_valid = 1'b0; flag_wr = 1'b0;
        check8("R10", "direct write priority", flags, 8'h50);

        // R8: all ones written, low nibble still zero.
        flag_wr = 1'b1; flag_wdata = 8'hFF;
        @(negedge clk);
        flag_wr = 1'b0;
        check8("R8", "all-ones write", flags, 8'hF0);

        // R6: OR with carry set ignores the carry and clears H and C.
        op_valid = 1'b1; op_code = 3'd6; opnd_a = 8'h12; opnd_b = 8'h21;
        #1;
        check8("R6", "OR result", alu_result, 8'h33);
        @(negedge clk);
        op_valid = 1'b0;
        check8("R6", "OR flags", flags, 8'h00);

        // R9: synchronous reset clears a nonzero register.
        flag_wr = 1'b1; flag_wdata = 8'hF0;
        @(negedge clk);
        flag_wr = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check8("R9", "flags after mid-run reset", flags, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule